// File: doc/BRIEF.md
# Hop-by-Hop Register Access Router

This block is one hub in a tree of interconnect hubs that carries 64-bit model-specific register reads and writes. Every request carries a 32-bit address. The upper 18 bits hold a source-relative route made of six 3-bit hop codes, and the lower 14 bits hold a register index. The hub looks only at the leading hop code. If the whole route is zero, the hub serves the access from its own small register file. Otherwise it passes the request to the outgoing channel named by the leading code. The route it passes on is moved up by one hop, so the next hub finds its own code in the top position.

The hub has one upstream port and up to seven downstream channels, numbered 1 to 7. Each direction uses a valid/ready handshake. Code 0 always means the hub itself, so no physical channel uses that number. A parameter mask marks which channels are connected. The hub keeps only one request in flight. It accepts a request, completes it locally, with an error, or through a downstream channel, and then hands the response upstream. Only after that response is taken does it accept the next request.

Top module: `msr_route_node`

## Requirements
- R1: The hub reads the route from address bits 31:14 and the register index from bits 13:0. The leading hop code is bits 31:29. A route of 2 then 3 with index 300h is address 0x4C000300.
- R2: A request whose route is all zero is a local access. No downstream valid is raised for it, and its response follows on the cycle after acceptance.
- R3: A request whose leading code c (1 to 7) is a connected channel is presented only on downstream channel c. Exactly that bit of `dn_req_valid` is set, and bit 0 is never set. The write flag and write data pass through unchanged.
- R4: The forwarded address is the route shifted left by 3 bits with zero fill, followed by the unchanged index. For example, 0x4C000300 is forwarded on channel 2 as 0x60000300.
- R5: The hub returns an error response (`up_rsp_err`=1, data 0) and makes no downstream transfer in two cases: the leading code names an unconnected channel, or the leading code is 0 while the rest of the route is non-zero.
- R6: From acceptance until the upstream response handshake completes, `up_req_ready` stays low. It is high in every other cycle.
- R7: The read data and error flag returned by the downstream channel reach the upstream response unchanged.
- R8: Local indices 0 to NREG-1 are 64-bit registers that reset to 0 and can be written and read back. A write response carries data 0 and no error.
- R9: A local read of an index at or above NREG returns 0. A local write to such an index changes no implemented register.
- R10: While a downstream request or an upstream response is valid and not yet accepted, its valid and payload hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Hub can accept a request |
| up_req_addr | input | 32 | Route (31:14) and index (13:0) |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_wdata | input | 64 | Write data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream takes the response |
| up_rsp_rdata | output | 64 | Read data (0 for writes and errors) |
| up_rsp_err | output | 1 | Routing or downstream error |
| dn_req_valid | output | 8 | Per-channel request valid; bit c is channel c, bit 0 unused |
| dn_req_ready | input | 8 | Per-channel request ready |
| dn_req_addr | output | 32 | Forwarded address, shared by all channels |
| dn_req_write | output | 1 | Forwarded write flag |
| dn_req_wdata | output | 64 | Forwarded write data |
| dn_rsp_valid | input | 8 | Per-channel response valid |
| dn_rsp_ready | output | 8 | Per-channel response ready |
| dn_rsp_rdata | input | 512 | Per-channel read data, channel c at bits 64c+63:64c |
| dn_rsp_err | input | 8 | Per-channel response error |

## Verification
The assertions check several properties on every cycle. At most one downstream channel is valid, and channel 0 is never valid. A stalled downstream request or upstream response holds its payload. A local or error request raises no downstream valid. The forwarded index and the returned response match what entered the hub. The bench scenarios are needed for the rest: the exact shifted route for a given address, the choice of channel against the connection mask, read-back of local registers after writes to valid and out-of-range indices, and the reference address 0x4C000300.

// File: rtl/msr_route_pkg.sv
package msr_route_pkg;
  localparam int ADDR_W  = 32;
  localparam int IDX_W   = 14;
  localparam int PATH_W  = ADDR_W - IDX_W;
  localparam int HOP_W   = 3;
  localparam int NCH     = 1 << HOP_W;

  typedef enum logic [1:0] {ST_IDLE, ST_FWD_REQ, ST_FWD_RSP, ST_RESP} node_st_e;
  typedef enum logic [1:0] {RT_LOCAL, RT_FWD, RT_ERR} route_e;

  function automatic logic [PATH_W-1:0] route_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  function automatic logic [HOP_W-1:0] lead_hop(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: HOP_W];
  endfunction

  function automatic logic [IDX_W-1:0] index_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] next_hop_addr(input logic [ADDR_W-1:0] a);
    logic [PATH_W-1:0] r;
    r = route_of(a) << HOP_W;
    return {r, index_of(a)};
  endfunction
endpackage

// File: rtl/msr_route_decode.sv
module msr_route_decode
  import msr_route_pkg::*;
#(
  parameter logic [NCH-1:0] CONN_MASK = 8'b0011_1110
) (
  input  logic [ADDR_W-1:0] addr,
  output route_e            route,
  output logic [HOP_W-1:0]  chan
);
  logic [PATH_W-1:0] path;
  assign path = route_of(addr);
  assign chan = lead_hop(addr);

  always_comb begin
    if (path == '0)              route = RT_LOCAL;
    else if (chan == '0)         route = RT_ERR;
    else if (CONN_MASK[chan])    route = RT_FWD;
    else                         route = RT_ERR;
  end
endmodule

// File: rtl/msr_local_regs.sv
module msr_local_regs
  import msr_route_pkg::*;
#(
  parameter int DW   = 64,
  parameter int NREG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] reg_vec [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          q <= '0;
      else if (we && idx == IDX_W'(r))     q <= wdata;
    end
    assign reg_vec[r] = q;
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NREG; r++)
      if (idx == IDX_W'(r)) rdata = reg_vec[r];
  end
endmodule

// File: rtl/msr_route_node.sv
module msr_route_node
  import msr_route_pkg::*;
#(
  parameter int               DW        = 64,
  parameter int               NREG      = 4,
  parameter logic [NCH-1:0]   CONN_MASK = 8'b0011_1110
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_req_valid,
  output logic                up_req_ready,
  input  logic [ADDR_W-1:0]   up_req_addr,
  input  logic                up_req_write,
  input  logic [DW-1:0]       up_req_wdata,
  output logic                up_rsp_valid,
  input  logic                up_rsp_ready,
  output logic [DW-1:0]       up_rsp_rdata,
  output logic                up_rsp_err,
  output logic [NCH-1:0]      dn_req_valid,
  input  logic [NCH-1:0]      dn_req_ready,
  output logic [ADDR_W-1:0]   dn_req_addr,
  output logic                dn_req_write,
  output logic [DW-1:0]       dn_req_wdata,
  input  logic [NCH-1:0]      dn_rsp_valid,
  output logic [NCH-1:0]      dn_rsp_ready,
  input  logic [NCH*DW-1:0]   dn_rsp_rdata,
  input  logic [NCH-1:0]      dn_rsp_err
);
  node_st_e           st;
  route_e             route;
  logic [HOP_W-1:0]   hop, ch_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               wr_q;
  logic [DW-1:0]      wdata_q, rsp_data_q, loc_rdata, sel_rdata;
  logic               rsp_err_q, sel_err;

  // named internal events
  logic req_fire, local_ev, fwd_ev, err_ev, dn_fire, dn_rsp_fire, up_done;

  msr_route_decode #(.CONN_MASK(CONN_MASK)) u_dec (
    .addr (up_req_addr),
    .route(route),
    .chan (hop)
  );

  msr_local_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (local_ev && up_req_write),
    .idx  (index_of(up_req_addr)),
    .wdata(up_req_wdata),
    .rdata(loc_rdata)
  );

  assign up_req_ready = (st == ST_IDLE);
  assign up_rsp_valid = (st == ST_RESP);
  assign up_rsp_rdata = rsp_data_q;
  assign up_rsp_err   = rsp_err_q;
  assign dn_req_addr  = addr_q;
  assign dn_req_write = wr_q;
  assign dn_req_wdata = wdata_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c == 0) begin : g_self
      assign dn_req_valid[c] = 1'b0;
      assign dn_rsp_ready[c] = 1'b0;
    end else begin : g_port
      assign dn_req_valid[c] = (st == ST_FWD_REQ) && (ch_q == HOP_W'(c));
      assign dn_rsp_ready[c] = (st == ST_FWD_RSP) && (ch_q == HOP_W'(c));
    end
  end

  assign sel_rdata   = dn_rsp_rdata[int'(ch_q)*DW +: DW];
  assign sel_err     = dn_rsp_err[ch_q];
  assign req_fire    = up_req_valid && up_req_ready;
  assign local_ev    = req_fire && (route == RT_LOCAL);
  assign fwd_ev      = req_fire && (route == RT_FWD);
  assign err_ev      = req_fire && (route == RT_ERR);
  assign dn_fire     = |(dn_req_valid & dn_req_ready);
  assign dn_rsp_fire = |(dn_rsp_valid & dn_rsp_ready);
  assign up_done     = up_rsp_valid && up_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ch_q       <= '0;
      addr_q     <= '0;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (local_ev) begin
            rsp_data_q <= up_req_write ? '0 : loc_rdata;
            rsp_err_q  <= 1'b0;
            st         <= ST_RESP;
          end else if (err_ev) begin
            rsp_data_q <= '0;
            rsp_err_q  <= 1'b1;
            st         <= ST_RESP;
          end else if (fwd_ev) begin
            ch_q    <= hop;
            addr_q  <= next_hop_addr(up_req_addr);
            wr_q    <= up_req_write;
            wdata_q <= up_req_wdata;
            st      <= ST_FWD_REQ;
          end
        end
        ST_FWD_REQ: if (dn_fire) st <= ST_FWD_RSP;
        ST_FWD_RSP: if (dn_rsp_fire) begin
          rsp_data_q <= sel_rdata;
          rsp_err_q  <= sel_err;
          st         <= ST_RESP;
        end
        ST_RESP:    if (up_done) st <= ST_IDLE;
        default:    st <= ST_IDLE;
      endcase
    end
  end

  AST_DN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_req_valid) && !dn_req_valid[0]); // R3
  AST_LOCAL_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    local_ev |=> (dn_req_valid == '0) && up_rsp_valid); // R2
  AST_ERR_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    err_ev |=> (dn_req_valid == '0) && up_rsp_err); // R5
  AST_FWD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ev |=> dn_req_addr[IDX_W-1:0] == $past(up_req_addr[IDX_W-1:0])); // R4
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid || dn_req_valid != '0) |-> !up_req_ready); // R6
  AST_RSP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rsp_fire |=> up_rsp_rdata == $past(sel_rdata) && up_rsp_err == $past(sel_err)); // R7
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    |(dn_req_valid & ~dn_req_ready) |=> $stable(dn_req_valid) && $stable(dn_req_addr)
      && $stable(dn_req_wdata) && $stable(dn_req_write)); // R10
  AST_UP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid && !up_rsp_ready |=> up_rsp_valid && $stable(up_rsp_rdata)
      && $stable(up_rsp_err)); // R10
endmodule

// File: tb/sim_msr_route_node.sv
module sim_msr_route_node;
  localparam int DW = 64;
  localparam logic [7:0] MASK = 8'b0011_1110;

  logic clk = 0, rst_n = 0;
  logic up_req_valid = 0, up_req_write = 0, up_rsp_ready = 0;
  logic [31:0] up_req_addr = '0;
  logic [63:0] up_req_wdata = '0;
  logic up_req_ready, up_rsp_valid, up_rsp_err, dn_req_write;
  logic [63:0] up_rsp_rdata, dn_req_wdata;
  logic [7:0] dn_req_valid, dn_rsp_ready;
  logic [7:0] dn_req_ready = '0, dn_rsp_valid = '0, dn_rsp_err = '0;
  logic [31:0] dn_req_addr;
  logic [8*DW-1:0] dn_rsp_rdata = '0;

  int checks = 0, failures = 0;
  bit busy = 0;

  always #10 clk = ~clk;

  msr_route_node u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference busy model: set on request acceptance, cleared on response handshake
  always @(posedge clk) begin
    if (!rst_n) busy <= 0;
    else if (up_req_valid && up_req_ready) busy <= 1;
    else if (up_rsp_valid && up_rsp_ready) busy <= 0;
  end
  always @(negedge clk) if (rst_n)
    chk(up_req_ready == !busy, "R6 ready vs busy model", 64'(up_req_ready), 64'(!busy));

  function automatic logic [31:0] exp_fwd(input logic [31:0] a);
    logic [17:0] r;
    r = 18'((a >> 14) * 8);
    return {r, a[13:0]};
  endfunction

  task automatic issue(input logic [31:0] a, input bit w, input logic [63:0] d);
    @(negedge clk);
    up_req_valid = 1; up_req_addr = a; up_req_write = w; up_req_wdata = d;
    while (!up_req_ready) @(negedge clk);
    @(negedge clk);
    up_req_valid = 0;
  endtask

  task automatic collect(input logic [63:0] ed, input bit ee, input string tag);
    logic [63:0] d0;
    while (!up_rsp_valid) @(negedge clk);
    chk(up_rsp_rdata == ed, {tag, " data"}, up_rsp_rdata, ed);
    chk(up_rsp_err == ee, {tag, " err"}, 64'(up_rsp_err), 64'(ee));
    d0 = up_rsp_rdata;
    @(negedge clk);
    chk(up_rsp_valid && up_rsp_rdata == d0, "R10 upstream hold", up_rsp_rdata, d0);
    up_rsp_ready = 1;
    @(negedge clk);
    up_rsp_ready = 0;
    chk(!up_rsp_valid && up_req_ready, "R6 released after response", 64'(up_req_ready), 64'd1);
  endtask

  task automatic local_acc(input logic [31:0] a, input bit w, input logic [63:0] d,
                           input logic [63:0] ed, input bit ee, input string tag);
    issue(a, w, d);
    chk(dn_req_valid == 8'h0, {tag, " no downstream"}, 64'(dn_req_valid), 64'd0);
    chk(up_rsp_valid, {tag, " response next cycle"}, 64'(up_rsp_valid), 64'd1);
    collect(ed, ee, tag);
  endtask

  task automatic fwd(input logic [31:0] a, input bit w, input logic [63:0] d, input int ch,
                     input int dly, input logic [63:0] rd, input bit re);
    issue(a, w, d);
    chk(dn_req_valid == 8'(1 << ch), "R3 channel select", 64'(dn_req_valid), 64'(1 << ch));
    chk(dn_req_addr == exp_fwd(a), "R4 shifted route", 64'(dn_req_addr), 64'(exp_fwd(a)));
    chk(dn_req_write == w && dn_req_wdata == d, "R3 payload passes", dn_req_wdata, d);
    for (int i = 0; i < dly; i++) @(negedge clk);
    chk(dn_req_valid == 8'(1 << ch) && dn_req_addr == exp_fwd(a), "R10 downstream hold",
        64'(dn_req_addr), 64'(exp_fwd(a)));
    dn_req_ready[ch] = 1;
    @(negedge clk);
    dn_req_ready = '0;
    chk(dn_req_valid == 0 && dn_rsp_ready == 8'(1 << ch), "R3 waits for response",
        64'(dn_rsp_ready), 64'(1 << ch));
    @(negedge clk);
    dn_rsp_valid[ch] = 1; dn_rsp_rdata[ch*DW +: DW] = rd; dn_rsp_err[ch] = re;
    @(negedge clk);
    dn_rsp_valid = '0; dn_rsp_err = '0;
    collect(rd, re, "R7 returned response");
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(up_req_ready && !up_rsp_valid && dn_req_valid == 0, "reset state",
        64'(up_req_ready), 64'd1);
    rst_n = 1;
    // R8: reset value, write then read back
    local_acc(32'h0000_0002, 0, 0, 64'h0, 0, "R8 reset read");
    local_acc(32'h0000_0001, 1, 64'hDEAD_BEEF_0123_4567, 64'h0, 0, "R8 write resp");
    local_acc(32'h0000_0003, 1, 64'h1111_2222_3333_4444, 64'h0, 0, "R8 write resp");
    local_acc(32'h0000_0001, 0, 0, 64'hDEAD_BEEF_0123_4567, 0, "R2 R8 read back");
    // R9: unimplemented indices
    local_acc(32'h0000_0100, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, "R9 write ignored");
    local_acc(32'h0000_0004, 1, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0, 0, "R9 write ignored");
    local_acc(32'h0000_0100, 0, 0, 64'h0, 0, "R9 read zero");
    local_acc(32'h0000_0000, 0, 0, 64'h0, 0, "R9 reg0 untouched");
    local_acc(32'h0000_0003, 0, 0, 64'h1111_2222_3333_4444, 0, "R9 reg3 untouched");
    // R1/R4 reference vector: hop 2 then 3, index 300h
    chk({3'd2, 3'd3, 12'd0, 14'h300} == 32'h4C00_0300, "R1 reference encoding",
        64'({3'd2, 3'd3, 12'd0, 14'h300}), 64'h4C00_0300);
    chk(exp_fwd(32'h4C00_0300) == 32'h6000_0300, "R4 reference forward",
        64'(exp_fwd(32'h4C00_0300)), 64'h6000_0300);
    fwd(32'h4C00_0300, 0, 0, 2, 2, 64'h0123_4567_89AB_CDEF, 0);
    fwd({3'd5, 3'd1, 3'd4, 9'd0, 14'h1ABC}, 1, 64'hCAFE_F00D_0000_0001, 5, 0, 64'h0, 0);
    fwd({3'd1, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 14'h3FFF}, 0, 0, 1, 3, 64'h5555_0000_5555_0000, 1);
    // R5: unconnected channel and bad leading zero
    local_acc({3'd6, 15'd0, 14'h10}, 0, 0, 64'h0, 1, "R5 unconnected ch6");
    local_acc({3'd7, 3'd1, 12'd0, 14'h0}, 1, 64'h77, 64'h0, 1, "R5 unconnected ch7");
    local_acc(32'h0000_4000, 0, 0, 64'h0, 1, "R5 zero lead nonzero route");
    local_acc(32'h0000_0001, 0, 0, 64'hDEAD_BEEF_0123_4567, 0, "R5 error write no effect");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule